// File: doc/BRIEF.md
# Coprocessor Instruction to Stream Channel Bridge

This block sits between a processor's coprocessor instruction port and a set of paired stream channels. Each pair has one outbound stream, which the bridge writes, and one inbound stream, which the bridge reads. Every stream word carries a data value and a single control bit. The processor issues one operation at a time. An operation is a 3-bit opcode, a 5-bit channel index and an operand word. The bridge answers with a one-cycle done pulse, a result word and two status flags.

The opcode picks one of eight operations from three choices: read or write, wait for the stream or give up at once, and data word or control word. A waiting operation keeps the processor stalled until the stream can move a word. A non-waiting operation finishes at once and raises a failure flag if no word could move. A read that receives a word with the wrong kind of control bit still consumes and returns that word, and raises a separate mismatch flag. A channel index at or above the configured pair count is rejected without touching any stream.

Top module: `cop_stream_bridge`

## Requirements
- R1: While `rst` is high and after it is released, `in_read`, `out_write`, `op_done`, `op_rdata`, `flag_fail` and `flag_kind` are all zero until the first operation completes.
- R2: Opcode bit 2 selects a write (1) or a read (0), bit 1 selects non-waiting (1) or waiting (0), and bit 0 selects a control word (1) or a data word (0). `op_valid` is taken only while no operation is in progress, and `op_valid` raised while an operation is in progress has no effect.
- R3: A read on a channel whose `in_exists` bit is high pulses that channel's `in_read` bit for one cycle, and in the next cycle `op_done` is high with `op_rdata` equal to the word read.
- R4: A write on a channel whose `out_full` bit is low pulses that channel's `out_write` bit for one cycle, with the operand on that channel's `out_data` slice and opcode bit 0 on its `out_ctrl` bit. `op_done` is high in the next cycle.
- R5: A waiting read gives no strobe and no `op_done` while `in_exists` of its channel is low. A waiting write does the same while `out_full` of its channel is high. Each proceeds as in R3 or R4 once the stream allows it.
- R6: A non-waiting operation whose stream is empty (read) or full (write) gives no strobe, completes one cycle after it is taken, and sets `flag_fail`. A read in this case returns zero.
- R7: A non-waiting operation that moves a word clears `flag_fail`. A waiting operation on a valid channel leaves `flag_fail` unchanged.
- R8: On every read that moves a word, `flag_kind` becomes 1 if the word's control bit differs from opcode bit 0 and 0 if it matches. Writes, failed reads and rejected operations leave `flag_kind` unchanged.
- R9: A channel index at or above `NUM_PAIRS` gives no strobe on any channel, completes one cycle after it is taken, and sets `flag_fail`. It returns zero for a read.
- R10: At most one bit of `in_read` and `out_write` together is high in any cycle, and `op_done` is never high for two cycles in a row.
- R11: A write leaves `op_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation request, taken when the bridge is idle |
| op_code | input | 3 | Operation selector (write, non-waiting, control) |
| op_chan | input | 5 | Channel pair index |
| op_wdata | input | DATA_W | Operand word for writes |
| op_done | output | 1 | One-cycle completion pulse |
| op_rdata | output | DATA_W | Result word of the last read |
| flag_fail | output | 1 | Non-waiting failure or rejected channel |
| flag_kind | output | 1 | Control-bit mismatch on the last moved read |
| in_data | input | NUM_PAIRS*DATA_W | Inbound words, channel i in slice i |
| in_ctrl | input | NUM_PAIRS | Inbound control bits |
| in_exists | input | NUM_PAIRS | Inbound word available |
| in_read | output | NUM_PAIRS | Inbound consume strobe |
| out_data | output | NUM_PAIRS*DATA_W | Outbound words, channel i in slice i |
| out_ctrl | output | NUM_PAIRS | Outbound control bits |
| out_write | output | NUM_PAIRS | Outbound push strobe |
| out_full | input | NUM_PAIRS | Outbound stream cannot take a word |

## Verification
The properties take for granted that a stream's `in_exists` and `out_full` bits reflect its state in the same cycle. A strobe is only legal against those levels, so the checks on strobes hold only while the stream side does not change them to cover a strobe already issued. The stimulus sets the stream levels between clock edges and holds them for the whole operation. The only exception is the single level change that releases a stalled operation. The stimulus also raises a stray request during stalls, to show that requests are ignored while an operation is in progress. The sweep covers every opcode against valid and out-of-range channels, ready and blocked streams, and both control-bit values.

// File: rtl/cop_stream_pkg.sv
package cop_stream_pkg;

   localparam int unsigned CHAN_IDX_W = 5;
   localparam int unsigned OPCODE_W   = 3;

   typedef struct packed {
      logic is_write;
      logic no_wait;
      logic is_ctrl;
   } op_attr_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } bridge_state_t;

   function automatic op_attr_t op_decode(input logic [OPCODE_W-1:0] code);
      op_attr_t a;
      a.is_write = code[2];
      a.no_wait  = code[1];
      a.is_ctrl  = code[0];
      return a;
   endfunction

endpackage

// File: rtl/cop_stream_sel_dec.sv
module cop_stream_sel_dec
   import cop_stream_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 4
) (
   input  logic [CHAN_IDX_W-1:0] idx,
   output logic [NUM_PAIRS-1:0]  hot,
   output logic                  ok
);

   generate
      if (NUM_PAIRS >= (1 << CHAN_IDX_W)) begin : g_full_range
         assign ok = 1'b1;
      end else begin : g_part_range
         assign ok = (idx < CHAN_IDX_W'(NUM_PAIRS));
      end

      for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_hot
         assign hot[i] = (idx == CHAN_IDX_W'(i));
      end
   endgenerate

endmodule

// File: rtl/cop_stream_in_sel.sv
module cop_stream_in_sel #(
   parameter int unsigned NUM_PAIRS = 4,
   parameter int unsigned DATA_W    = 32
) (
   input  logic [NUM_PAIRS*DATA_W-1:0] in_data,
   input  logic [NUM_PAIRS-1:0]        in_ctrl,
   input  logic [NUM_PAIRS-1:0]        in_exists,
   input  logic [NUM_PAIRS-1:0]        hot,
   input  logic                        pop,
   output logic [DATA_W-1:0]           word,
   output logic                        word_ctrl,
   output logic                        word_here,
   output logic [NUM_PAIRS-1:0]        in_read
);

   generate
      if (NUM_PAIRS == 1) begin : g_single
         assign word      = in_data;
         assign word_ctrl = in_ctrl[0];
         assign word_here = in_exists[0] & hot[0];
      end else begin : g_multi
         always_comb begin
            word      = '0;
            word_ctrl = 1'b0;
            word_here = 1'b0;
            for (int i = 0; i < NUM_PAIRS; i++) begin
               if (hot[i]) begin
                  word      = in_data[i*DATA_W +: DATA_W];
                  word_ctrl = in_ctrl[i];
                  word_here = in_exists[i];
               end
            end
         end
      end
   endgenerate

   assign in_read = hot & {NUM_PAIRS{pop}};

endmodule

// File: rtl/cop_stream_out_fan.sv
module cop_stream_out_fan #(
   parameter int unsigned NUM_PAIRS = 4,
   parameter int unsigned DATA_W    = 32
) (
   input  logic [DATA_W-1:0]           wdata,
   input  logic                        wctrl,
   input  logic [NUM_PAIRS-1:0]        hot,
   input  logic                        push,
   input  logic [NUM_PAIRS-1:0]        out_full,
   output logic [NUM_PAIRS*DATA_W-1:0] out_data,
   output logic [NUM_PAIRS-1:0]        out_ctrl,
   output logic [NUM_PAIRS-1:0]        out_write,
   output logic                        sel_full
);

   generate
      for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_lane
         assign out_data[i*DATA_W +: DATA_W] = wdata;
         assign out_ctrl[i]                  = wctrl;
      end
   endgenerate

   assign out_write = hot & {NUM_PAIRS{push}};
   assign sel_full  = |(out_full & hot);

endmodule

// File: rtl/cop_stream_bridge.sv
module cop_stream_bridge
   import cop_stream_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 4,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        op_valid,
   input  logic [2:0]                  op_code,
   input  logic [4:0]                  op_chan,
   input  logic [DATA_W-1:0]           op_wdata,
   output logic                        op_done,
   output logic [DATA_W-1:0]           op_rdata,
   output logic                        flag_fail,
   output logic                        flag_kind,
   input  logic [NUM_PAIRS*DATA_W-1:0] in_data,
   input  logic [NUM_PAIRS-1:0]        in_ctrl,
   input  logic [NUM_PAIRS-1:0]        in_exists,
   output logic [NUM_PAIRS-1:0]        in_read,
   output logic [NUM_PAIRS*DATA_W-1:0] out_data,
   output logic [NUM_PAIRS-1:0]        out_ctrl,
   output logic [NUM_PAIRS-1:0]        out_write,
   input  logic [NUM_PAIRS-1:0]        out_full
);

   generate
      if (NUM_PAIRS < 1 || NUM_PAIRS > 32) begin : g_bad_pairs
         $error("cop_stream_bridge: NUM_PAIRS must lie in 1..32");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("cop_stream_bridge: DATA_W must be at least 1");
      end
   endgenerate

   bridge_state_t         state;
   op_attr_t              lat_attr;
   logic [CHAN_IDX_W-1:0] lat_chan;
   logic [DATA_W-1:0]     lat_wdata;

   logic [NUM_PAIRS-1:0]  sel_hot;
   logic                  sel_ok;
   logic [DATA_W-1:0]     sel_word;
   logic                  sel_word_ctrl;
   logic                  sel_here;
   logic                  sel_full;
   logic                  busy;
   logic                  pop;
   logic                  push;
   logic                  finish;

   cop_stream_sel_dec #(
      .NUM_PAIRS (NUM_PAIRS)
   ) u_sel_dec (
      .idx (lat_chan),
      .hot (sel_hot),
      .ok  (sel_ok)
   );

   cop_stream_in_sel #(
      .NUM_PAIRS (NUM_PAIRS),
      .DATA_W    (DATA_W)
   ) u_in_sel (
      .in_data   (in_data),
      .in_ctrl   (in_ctrl),
      .in_exists (in_exists),
      .hot       (sel_hot),
      .pop       (pop),
      .word      (sel_word),
      .word_ctrl (sel_word_ctrl),
      .word_here (sel_here),
      .in_read   (in_read)
   );

   cop_stream_out_fan #(
      .NUM_PAIRS (NUM_PAIRS),
      .DATA_W    (DATA_W)
   ) u_out_fan (
      .wdata     (lat_wdata),
      .wctrl     (lat_attr.is_ctrl),
      .hot       (sel_hot),
      .push      (push),
      .out_full  (out_full),
      .out_data  (out_data),
      .out_ctrl  (out_ctrl),
      .out_write (out_write),
      .sel_full  (sel_full)
   );

   // Strobes are combinational in the busy cycle that moves the word;
   // the done pulse and the results follow one register later.
   always_comb begin
      busy   = (state == ST_BUSY);
      pop    = busy && sel_ok && !lat_attr.is_write && sel_here;
      push   = busy && sel_ok &&  lat_attr.is_write && !sel_full;
      finish = 1'b0;
      if (busy) begin
         if (!sel_ok) begin
            finish = 1'b1;
         end else if (lat_attr.is_write) begin
            finish = !sel_full || lat_attr.no_wait;
         end else begin
            finish = sel_here || lat_attr.no_wait;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         lat_attr  <= '0;
         lat_chan  <= '0;
         lat_wdata <= '0;
         op_done   <= 1'b0;
         op_rdata  <= '0;
         flag_fail <= 1'b0;
         flag_kind <= 1'b0;
      end else begin
         op_done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (op_valid) begin
                  lat_attr  <= op_decode(op_code);
                  lat_chan  <= op_chan;
                  lat_wdata <= op_wdata;
                  state     <= ST_BUSY;
               end
            end
            ST_BUSY: begin
               if (finish) begin
                  op_done <= 1'b1;
                  state   <= ST_IDLE;
                  if (!sel_ok) begin
                     flag_fail <= 1'b1;
                     if (!lat_attr.is_write) op_rdata <= '0;
                  end else if (lat_attr.is_write) begin
                     if (push) begin
                        if (lat_attr.no_wait) flag_fail <= 1'b0;
                     end else begin
                        flag_fail <= 1'b1;
                     end
                  end else begin
                     if (pop) begin
                        op_rdata  <= sel_word;
                        flag_kind <= sel_word_ctrl ^ lat_attr.is_ctrl;
                        if (lat_attr.no_wait) flag_fail <= 1'b0;
                     end else begin
                        op_rdata  <= '0;
                        flag_fail <= 1'b1;
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cop_stream_bridge_chk.sv
module cop_stream_bridge_chk #(
   parameter int unsigned NUM_PAIRS = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 op_done,
   input logic                 flag_fail,
   input logic                 flag_kind,
   input logic [NUM_PAIRS-1:0] in_exists,
   input logic [NUM_PAIRS-1:0] in_read,
   input logic [NUM_PAIRS-1:0] out_full,
   input logic [NUM_PAIRS-1:0] out_write
);

   p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
      $onehot0({in_read, out_write}));

   p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
      op_done |=> !op_done);

   p_read_has_word_r5: assert property (@(posedge clk) disable iff (rst)
      (in_read & ~in_exists) == '0);

   p_write_has_room_r5: assert property (@(posedge clk) disable iff (rst)
      (out_write & out_full) == '0);

   p_read_then_done_r3: assert property (@(posedge clk) disable iff (rst)
      (|in_read) |=> op_done);

   p_write_then_done_r4: assert property (@(posedge clk) disable iff (rst)
      (|out_write) |=> op_done);

   p_fail_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !op_done |-> $stable(flag_fail));

   p_kind_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      !op_done |-> $stable(flag_kind));

endmodule

bind cop_stream_bridge cop_stream_bridge_chk #(
   .NUM_PAIRS (NUM_PAIRS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .op_done   (op_done),
   .flag_fail (flag_fail),
   .flag_kind (flag_kind),
   .in_exists (in_exists),
   .in_read   (in_read),
   .out_full  (out_full),
   .out_write (out_write)
);

// File: tb/test_cop_stream_bridge.sv
module test_cop_stream_bridge;

   localparam int NCH = 3;
   localparam int DW  = 8;
   localparam int HALF = 10; // 20 ns period, 50 MHz

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              op_valid = 1'b0;
   logic [2:0]        op_code = '0;
   logic [4:0]        op_chan = '0;
   logic [DW-1:0]     op_wdata = '0;
   logic              op_done;
   logic [DW-1:0]     op_rdata;
   logic              flag_fail;
   logic              flag_kind;
   logic [NCH*DW-1:0] in_data = '0;
   logic [NCH-1:0]    in_ctrl = '0;
   logic [NCH-1:0]    in_exists = '0;
   logic [NCH-1:0]    in_read;
   logic [NCH*DW-1:0] out_data;
   logic [NCH-1:0]    out_ctrl;
   logic [NCH-1:0]    out_write;
   logic [NCH-1:0]    out_full = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   int            rd_cnt [NCH];
   int            wr_cnt [NCH];
   logic [DW-1:0] wr_data_seen;
   logic          wr_ctrl_seen;

   logic [DW-1:0] exp_rdata = '0;
   logic          exp_fail  = 1'b0;
   logic          exp_kind  = 1'b0;

   always #HALF clk = ~clk;

   cop_stream_bridge #(
      .NUM_PAIRS (NCH),
      .DATA_W    (DW)
   ) i_cop_stream_bridge (
      .clk       (clk),
      .rst       (rst),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .op_chan   (op_chan),
      .op_wdata  (op_wdata),
      .op_done   (op_done),
      .op_rdata  (op_rdata),
      .flag_fail (flag_fail),
      .flag_kind (flag_kind),
      .in_data   (in_data),
      .in_ctrl   (in_ctrl),
      .in_exists (in_exists),
      .in_read   (in_read),
      .out_data  (out_data),
      .out_ctrl  (out_ctrl),
      .out_write (out_write),
      .out_full  (out_full)
   );

   // Strobe monitor, sampling 15 ns after each rising edge.
   always begin
      @(posedge clk);
      #15;
      for (int i = 0; i < NCH; i++) begin
         if (in_read[i]) rd_cnt[i]++;
         if (out_write[i]) begin
            wr_cnt[i]++;
            wr_data_seen = out_data[i*DW +: DW];
            wr_ctrl_seen = out_ctrl[i];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic check_idle_outputs(input string req);
      chk(op_done == 1'b0, req, "op_done", int'(op_done), 0);
      chk(op_rdata == '0, req, "op_rdata", int'(op_rdata), 0);
      chk(flag_fail == 1'b0, req, "flag_fail", int'(flag_fail), 0);
      chk(flag_kind == 1'b0, req, "flag_kind", int'(flag_kind), 0);
      chk(in_read == '0 && out_write == '0, req, "strobes",
          int'({in_read, out_write}), 0);
   endtask

   task automatic run_op(input logic [2:0] code, input logic [4:0] ch,
                         input bit ready, input bit wctl,
                         input logic [DW-1:0] wd, input logic [DW-1:0] rword);
      bit is_wr = code[2];
      bit nb    = code[1];
      bit cb    = code[0];
      bit valid = (int'(ch) < NCH);
      bit stall = valid && !nb && !ready;
      bit xfer  = valid && (ready || !nb);
      int waited = 0;
      string rq;

      // Unselected channels are kept ready to expose a wrong selection.
      for (int i = 0; i < NCH; i++) begin
         in_exists[i] = 1'b1;
         in_ctrl[i]   = ~wctl;
         in_data[i*DW +: DW] = ~rword;
         out_full[i]  = 1'b0;
         rd_cnt[i] = 0;
         wr_cnt[i] = 0;
      end
      if (valid) begin
         in_exists[ch] = ready;
         in_ctrl[ch]   = wctl;
         in_data[int'(ch)*DW +: DW] = rword;
         out_full[ch]  = ~ready;
      end

      if (!valid) begin
         exp_fail = 1'b1;
         if (!is_wr) exp_rdata = '0;
      end else if (xfer) begin
         if (!is_wr) begin
            exp_rdata = rword;
            exp_kind  = wctl ^ cb;
         end
         if (nb) exp_fail = 1'b0;
      end else begin
         exp_fail = 1'b1;
         if (!is_wr) exp_rdata = '0;
      end

      @(negedge clk);
      op_valid = 1'b1;
      op_code  = code;
      op_chan  = ch;
      op_wdata = wd;
      @(negedge clk);
      op_valid = 1'b0;

      forever begin
         @(posedge clk);
         #5;
         if (stall && waited == 1) begin
            // stray request during a stall (R2): a non-waiting control write to ch 0
            op_valid = 1'b1;
            op_code  = 3'b111;
            op_chan  = 5'd0;
            op_wdata = 8'hA5;
         end
         if (stall && waited == 2) op_valid = 1'b0;
         if (stall && waited == 3) begin
            if (is_wr) out_full[ch] = 1'b0;
            else       in_exists[ch] = 1'b1;
         end
         #10;
         if (op_done) break;
         waited++;
         if (waited > 40) break;
      end

      rq = stall ? "R5" : (valid ? (nb && !ready ? "R6" : (is_wr ? "R4" : "R3")) : "R9");
      chk(waited == (stall ? 4 : 0), rq, "cycles to done", waited, stall ? 4 : 0);
      chk(op_rdata == exp_rdata, is_wr ? "R11" : rq, "op_rdata",
          int'(op_rdata), int'(exp_rdata));
      chk(flag_fail == exp_fail, (valid && xfer) ? "R7" : rq, "flag_fail",
          int'(flag_fail), int'(exp_fail));
      chk(flag_kind == exp_kind, "R8", "flag_kind", int'(flag_kind), int'(exp_kind));
      for (int i = 0; i < NCH; i++) begin
         int er = (xfer && !is_wr && i == int'(ch)) ? 1 : 0;
         int ew = (xfer &&  is_wr && i == int'(ch)) ? 1 : 0;
         chk(rd_cnt[i] == er, is_wr ? "R2" : rq, "in_read pulses", rd_cnt[i], er);
         chk(wr_cnt[i] == ew, is_wr ? rq : "R2", "out_write pulses", wr_cnt[i], ew);
      end
      if (xfer && is_wr) begin
         chk(wr_data_seen == wd, "R4", "out_data", int'(wr_data_seen), int'(wd));
         chk(wr_ctrl_seen == cb, "R4", "out_ctrl", int'(wr_ctrl_seen), int'(cb));
      end

      @(posedge clk);
      #15;
      chk(op_done == 1'b0, "R10", "op_done second cycle", int'(op_done), 0);
      @(posedge clk);
      #15;
      chk(op_done == 1'b0, "R2", "op_done after stray request", int'(op_done), 0);
   endtask

   initial begin
      #(200000 * 2 * HALF);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [4:0] chans [5];
      chans[0] = 5'd0; chans[1] = 5'd1; chans[2] = 5'd2;
      chans[3] = 5'd3; chans[4] = 5'd31;
      for (int i = 0; i < NCH; i++) begin
         rd_cnt[i] = 0;
         wr_cnt[i] = 0;
      end

      repeat (3) @(posedge clk);
      #15;
      check_idle_outputs("R1");
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #15;
      check_idle_outputs("R1");

      for (int code = 0; code < 8; code++) begin
         for (int ci = 0; ci < 5; ci++) begin
            for (int rdy = 0; rdy < 2; rdy++) begin
               for (int wc = 0; wc < 2; wc++) begin
                  logic [DW-1:0] rw;
                  rw = DW'(code * 29 + ci * 7 + rdy * 3 + wc + 1);
                  run_op(3'(code), chans[ci], bit'(rdy), bit'(wc), ~rw, rw);
               end
            end
         end
      end

      // Reset in mid-run restores the quiet state.
      run_op(3'b010, 5'd1, 1'b0, 1'b0, 8'h00, 8'h5C);
      run_op(3'b001, 5'd2, 1'b1, 1'b0, 8'h00, 8'hC3);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #15;
      check_idle_outputs("R1");
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #15;
      check_idle_outputs("R1");

      finish_run();
   end

endmodule